// File: doc/BRIEF.md
# PAUSE Frame Transmit Controller

This block lets software request a MAC control frame that asks the link partner to hold off transmission for a given time. Software programs one 32-bit flow-control word. The word holds a 16-bit pause time in its upper half, a pass-control mode bit, a flow-control enable bit and a busy bit in bit 0. Writing the word with bit 0 set starts one frame, provided the link is in full duplex. The busy bit then reads back as 1 until the final byte of the frame has been accepted downstream.

The frame leaves the block as a byte stream with a valid/ready handshake and an end-of-frame flag. The downstream MAC adds the preamble, the start delimiter and the FCS. In half duplex no frame is ever built. The enable bit instead raises a backpressure request toward the MAC.

Top module: `pause_tx_ctrl`

## Requirements
- R1: After synchronous reset, the register reads 0x0000_0000, and `tx_valid`, `tx_last` and `backpressure_req` are 0.
- R2: A write while busy reads 0 stores bits 31:16 (pause time), bit 2 (pass control) and bit 1 (enable). If bit 0 of the write is 1 and `full_duplex` is 1, busy reads 1 and `tx_valid` is 1 from the next cycle on.
- R3: The frame is 60 bytes, sent in this order: 01 80 C2 00 00 01, then the station address most significant byte first, then 88 08, then 00 01, then the pause time high byte then low byte, then 42 zero bytes.
- R4: Busy and `tx_valid` stay 1 until byte 60 is accepted. Both read 0 in the cycle after that acceptance.
- R5: A write that arrives while busy reads 1 changes no register bit.
- R6: A byte is consumed only in a cycle where `tx_valid` and `tx_ready` are both 1. While `tx_ready` is 0, `tx_data` and `tx_last` hold.
- R7: `tx_last` is 1 exactly while byte 60 is presented.
- R8: With `full_duplex` at 0, a write with bit 0 set starts no frame and busy stays 0. `backpressure_req` equals the enable bit AND NOT `full_duplex`.
- R9: Bits 15:3 always read 0, whatever was written to them.
- R10: The station address is sampled on the cycle a frame starts. Later changes do not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write value |
| reg_rd_data | output | 32 | Current register value |
| full_duplex | input | 1 | Link duplex mode, 1 = full |
| station_addr | input | 48 | Own MAC address used as source |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_last | output | 1 | Marks the final frame byte |
| tx_ready | input | 1 | Downstream accepts the byte |
| backpressure_req | output | 1 | Half-duplex backpressure request |

## Verification
A byte counter that skips or repeats an index shows up as a wrong `tx_data` value in the same cycle it is presented. A busy flag that falls early or late separates `tx_valid` from the read-back busy bit and shifts `tx_last`. Both show within one clock of the fault. A lost or wrongly accepted write shows on the very next read of the register. The bench compares every output against a behavioural model on every cycle, so any such fault shows on the first affected cycle.

// File: rtl/pause_pkg.sv
package pause_pkg;

    localparam int FRAME_BYTES = 60;
    localparam int PT_W        = 16;
    localparam int SA_W        = 48;
    localparam int IDX_W       = $clog2(FRAME_BYTES);
    localparam int RSV_LO      = 3;
    localparam int RSV_HI      = 15;

    localparam logic [47:0] PAUSE_DEST   = 48'h0180_C200_0001;
    localparam logic [15:0] CTRL_TYPE    = 16'h8808;
    localparam logic [15:0] PAUSE_OPCODE = 16'h0001;

    localparam int OFS_SA  = 6;
    localparam int OFS_TYP = 12;
    localparam int OFS_OP  = 14;
    localparam int OFS_PT  = 16;
    localparam int OFS_PAD = 18;

    typedef struct packed {
        logic [PT_W-1:0] pause_time;
        logic            pass_ctrl;
        logic            fc_enable;
        logic            busy;
    } fc_reg_t;

    function automatic logic [7:0] pick_byte48(input logic [47:0] v, input int pos);
        logic [47:0] sh;
        sh = v >> (8 * (5 - pos));
        return sh[7:0];
    endfunction

    function automatic logic [7:0] frame_byte(input logic [IDX_W-1:0] idx,
                                              input logic [SA_W-1:0]  sa,
                                              input logic [PT_W-1:0]  pt);
        int i;
        i = int'(idx);
        if (i < OFS_SA)            return pick_byte48(PAUSE_DEST, i);
        else if (i < OFS_TYP)      return pick_byte48(sa, i - OFS_SA);
        else if (i == OFS_TYP)     return CTRL_TYPE[15:8];
        else if (i == OFS_TYP + 1) return CTRL_TYPE[7:0];
        else if (i == OFS_OP)      return PAUSE_OPCODE[15:8];
        else if (i == OFS_OP + 1)  return PAUSE_OPCODE[7:0];
        else if (i == OFS_PT)      return pt[15:8];
        else if (i == OFS_PT + 1)  return pt[7:0];
        else                       return 8'h00;
    endfunction

    function automatic logic [31:0] pack_readback(input fc_reg_t r);
        logic [31:0] w;
        w = '0;
        w[31:16] = r.pause_time;
        w[2]     = r.pass_ctrl;
        w[1]     = r.fc_enable;
        w[0]     = r.busy;
        return w;
    endfunction

endpackage

// File: rtl/pause_fc_reg.sv
module pause_fc_reg
    import pause_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        full_duplex,
    input  logic        frame_done,
    output fc_reg_t     regs,
    output logic        start
);

    logic accept;

    assign accept = wr_en && !regs.busy;
    assign start  = accept && wr_data[0] && full_duplex;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (accept) begin
            regs.pause_time <= wr_data[31:16];
            regs.pass_ctrl  <= wr_data[2];
            regs.fc_enable  <= wr_data[1];
            regs.busy       <= start;
        end else if (frame_done) begin
            regs.busy <= 1'b0;
        end
    end

    AST_WRITE_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        regs.busy && wr_en |=> $stable(regs.pause_time) && $stable(regs.fc_enable) && $stable(regs.pass_ctrl)); // R5

    AST_HALF_DUPLEX_NO_START: assert property (@(posedge clk) disable iff (rst)
        wr_en && !full_duplex && !regs.busy |=> !regs.busy); // R8

endmodule

// File: rtl/pause_frame_seq.sv
module pause_frame_seq
    import pause_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [SA_W-1:0] station_addr,
    input  logic [PT_W-1:0] pause_time,
    input  logic            tx_ready,
    output logic            tx_valid,
    output logic [7:0]      tx_data,
    output logic            tx_last,
    output logic            frame_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    logic             active;
    logic [IDX_W-1:0] idx;
    logic [SA_W-1:0]  sa_q;
    logic             fire;

    assign fire       = active && tx_ready;
    assign tx_valid   = active;
    assign tx_last    = active && (idx == LAST_IDX);
    assign frame_done = fire && (idx == LAST_IDX);
    assign tx_data    = frame_byte(idx, sa_q, pause_time);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            sa_q   <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            idx    <= '0;
            sa_q   <= station_addr;
        end else if (fire) begin
            if (idx == LAST_IDX) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R6

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid); // R7

    AST_DONE_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !tx_valid); // R4

endmodule

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
    import pause_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    input  logic        full_duplex,
    input  logic [47:0] station_addr,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        backpressure_req
);

    fc_reg_t regs;
    logic    start;
    logic    frame_done;

    pause_fc_reg i_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .full_duplex(full_duplex),
        .frame_done (frame_done),
        .regs       (regs),
        .start      (start)
    );

    pause_frame_seq i_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .station_addr(station_addr),
        .pause_time  (regs.pause_time),
        .tx_ready    (tx_ready),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_last     (tx_last),
        .frame_done  (frame_done)
    );

    assign reg_rd_data      = pack_readback(regs);
    assign backpressure_req = regs.fc_enable && !full_duplex;

    AST_BUSY_TRACKS_VALID: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[0] == tx_valid); // R4

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[RSV_HI:RSV_LO] == '0); // R9

endmodule

// File: tb/test_pause_tx_ctrl.sv
module test_pause_tx_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        full_duplex = 1'b1;
    logic [47:0] station_addr = 48'h0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_last;
    logic        tx_ready = 1'b0;
    logic        backpressure_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    logic [15:0] m_pt;
    logic        m_pcf, m_fce, m_busy;
    int          m_idx;
    logic [7:0]  m_frame [NBYTES];

    pause_tx_ctrl i_pause_tx_ctrl (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .full_duplex(full_duplex), .station_addr(station_addr),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .backpressure_req(backpressure_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Behavioural reference: update on each rising edge from bench-driven inputs.
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_pt = '0; m_pcf = 0; m_fce = 0; m_busy = 0; m_idx = 0;
        end else begin
            logic old_busy;
            old_busy = m_busy;
            if (m_busy && tx_ready) begin
                if (m_idx == NBYTES-1) begin m_busy = 0; m_idx = 0; end
                else m_idx++;
            end
            if (reg_wr_en && !old_busy) begin
                m_pt  = reg_wr_data[31:16];
                m_pcf = reg_wr_data[2];
                m_fce = reg_wr_data[1];
                if (reg_wr_data[0] && full_duplex) begin
                    m_busy = 1; m_idx = 0;
                    for (int k = 0; k < NBYTES; k++) m_frame[k] = 8'h00;
                    m_frame[0] = 8'h01; m_frame[1] = 8'h80; m_frame[2] = 8'hC2;
                    m_frame[3] = 8'h00; m_frame[4] = 8'h00; m_frame[5] = 8'h01;
                    for (int k = 0; k < 6; k++) m_frame[6+k] = station_addr[47-8*k -: 8];
                    m_frame[12] = 8'h88; m_frame[13] = 8'h08;
                    m_frame[14] = 8'h00; m_frame[15] = 8'h01;
                    m_frame[16] = m_pt[15:8]; m_frame[17] = m_pt[7:0];
                end
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R9 readback", reg_rd_data, {m_pt, 13'b0, m_pcf, m_fce, m_busy});
            chk("R4 tx_valid", 32'(tx_valid), 32'(m_busy));
            chk("R7 tx_last", 32'(tx_last), 32'(m_busy && m_idx == NBYTES-1));
            chk("R8 backpressure", 32'(backpressure_req), 32'(m_fce && !full_duplex));
            if (m_busy) chk("R3 tx_data", 32'(tx_data), 32'(m_frame[m_idx]));
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic write_reg(input logic [31:0] v);
        @(negedge clk); #1;
        reg_wr_en = 1; reg_wr_data = v;
        @(negedge clk); #1;
        reg_wr_en = 0;
    endtask

    task automatic wait_idle(input int mode);
        int n = 0;
        while (m_busy) begin
            @(negedge clk); #1;
            n++;
            case (mode)
                0: tx_ready = 1;
                1: tx_ready = (n % 3) != 0;
                default: tx_ready = (n % 2) == 0;
            endcase
        end
        @(negedge clk); #1;
        tx_ready = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset reg", reg_rd_data, 32'h0);
        chk("R1 reset valid", 32'(tx_valid), 0);
        chk("R1 reset bp", 32'(backpressure_req), 0);

        // R2: start a frame in full duplex
        station_addr = 48'h02_11_22_33_44_55;
        write_reg(32'h1234_0007);
        chk("R2 busy set", 32'(reg_rd_data[0]), 1);
        chk("R2 valid", 32'(tx_valid), 1);
        // R6: stall holds data
        @(negedge clk);
        chk("R6 stall data", 32'(tx_data), 32'h01);
        // R10: change source address mid-frame
        station_addr = 48'hFF_EE_DD_CC_BB_AA;
        // R5: write while busy ignored
        write_reg(32'h5555_0002);
        chk("R5 pt kept", 32'(reg_rd_data[31:16]), 32'h1234);
        wait_idle(1);
        chk("R4 busy clear", 32'(reg_rd_data[0]), 0);

        // R9: reserved bits written high, frame with ready always high
        write_reg(32'hABCD_FFFB);
        chk("R9 reserved", 32'(reg_rd_data[15:3]), 0);
        wait_idle(0);

        // R8: half duplex
        full_duplex = 0;
        write_reg(32'h7777_0003);
        chk("R8 no start", 32'(tx_valid), 0);
        chk("R8 bp on", 32'(backpressure_req), 1);
        @(negedge clk); #1;
        full_duplex = 1;
        @(negedge clk);
        chk("R8 bp off", 32'(backpressure_req), 0);

        // zero pause time, alternating ready; R10 frame uses address at start
        write_reg(32'h0000_0001);
        wait_idle(2);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule